// File: doc/BRIEF.md
# Protection Fault Qualifier and Output Driver

This block sits behind the cell and temperature comparators of a battery pack protector. It takes five raw fault conditions (cell over-voltage, cell under-voltage, broken sense wire, over-temperature and a slow internal oscillator). Each condition must persist for its own delay before it counts. The block then steers the qualified faults onto two protection lines. The charge line is for charge-path cutoff and the discharge line is for discharge-path cutoff. Each line is driven at a strapped polarity.

Time is measured in ticks of a slow enable, nominally 1 kHz. The over-voltage and under-voltage delays each come from a 3-bit strap. Broken-wire and over-temperature always use the longest delay. The oscillator fault acts at once. A test request swaps every delay for a short fixed one so that a production line can check the timing quickly. A latch strap makes every output fault sticky until reset. A status bit reports whether the block is in fault mode.

Top module: `fdt_prot_ctrl`

## Requirements
- R1: During and right after reset, both lines sit at their inactive level (the complement of `pol_high`) and `fault_mode` is 0.
- R2: An over-voltage condition drives the charge line active in the cycle after the N-th tick seen while the condition is held, where N = BASE_TICKS << s and s is `ov_dly_sel` (codes 0 to 4; codes 5 to 7 act as 4). Cycles without `tick` do not count. The discharge line is unaffected.
- R3: An under-voltage condition drives only the discharge line, with the same delay rule using `uv_dly_sel`.
- R4: A broken-wire or over-temperature condition drives both lines active after BASE_TICKS << 4 ticks.
- R5: An oscillator fault drives both lines active in the cycle after it rises, with no delay, and releases them in the cycle after it falls.
- R6: If a condition drops for even one cycle before its delay expires, its timer restarts from zero.
- R7: Without the latch, a line returns to inactive in the cycle after every condition mapped to it has dropped. A qualified fault on one line does not hold the other line.
- R8: With `latch_en` high, an active line stays active after its conditions drop, until reset.
- R9: While `test_req` is held, every delayed condition qualifies after TEST_TICKS ticks. Once the request is withdrawn, the strapped delays apply again.
- R10: A change of `test_req` restarts every running timer. The timer then needs its full new delay, counted from the tick after the change.
- R11: `pol_high` = 1 gives active level 1 and `pol_high` = 0 gives active level 0. The inactive level is always the opposite.
- R12: `fault_mode` is 1 exactly when at least one line is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable from the slow timebase |
| raw_ov | input | 1 | Raw cell over-voltage condition |
| raw_uv | input | 1 | Raw cell under-voltage condition |
| raw_ow | input | 1 | Raw broken sense wire condition |
| raw_ot | input | 1 | Raw over-temperature condition |
| raw_osc | input | 1 | Raw oscillator-slow condition |
| ov_dly_sel | input | 3 | Over-voltage delay code |
| uv_dly_sel | input | 3 | Under-voltage delay code |
| latch_en | input | 1 | Strap: faults stick until reset |
| pol_high | input | 1 | Strap: lines are active high when 1 |
| test_req | input | 1 | Request for shortened delays |
| chg_out | output | 1 | Charge protection line level |
| dsg_out | output | 1 | Discharge protection line level |
| fault_mode | output | 1 | 1 in fault mode, 0 in normal mode |

## Verification
A timer that holds a wrong count shows up at the lines as activation that comes early or late by a whole number of ticks. Every delay code is therefore measured in ticks, both with a tick on every cycle and with a sparse tick. A stale timer is exposed by dropping a condition for one cycle just before expiry, and by flipping the test request mid-count. Either case moves activation by many ticks within one delay period. A routing or latch error appears within a single cycle of a condition changing, on the line that should have stayed quiet or released.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

   typedef enum logic [2:0] {
      F_OV  = 3'd0,
      F_UV  = 3'd1,
      F_OW  = 3'd2,
      F_OT  = 3'd3,
      F_OSC = 3'd4
   } fault_e;

   localparam int NUM_FAULTS = 5;
   localparam int SEL_W      = 3;
   localparam int MAX_SHIFT  = 4;

   // bit i set: fault i drives the line
   localparam logic [NUM_FAULTS-1:0] CHG_ROUTE = 5'b11101;
   localparam logic [NUM_FAULTS-1:0] DSG_ROUTE = 5'b11110;

   // codes above the longest option saturate to it
   function automatic int unsigned shift_of(input logic [SEL_W-1:0] code);
      return (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
   endfunction

endpackage

// File: rtl/fdt_delay_sel.sv
module fdt_delay_sel
   import fdt_pkg::*;
#(
   parameter int BASE_TICKS = 250,
   parameter int TEST_TICKS = 50,
   parameter int CNT_W      = 12
) (
   input  logic [SEL_W-1:0] code,
   input  logic             test_on,
   output logic [CNT_W-1:0] limit
);

   logic [31:0] normal_ticks;

   always_comb begin
      normal_ticks = 32'(BASE_TICKS) << shift_of(code);
      if (test_on) limit = CNT_W'(TEST_TICKS);
      else         limit = CNT_W'(normal_ticks);
   end

endmodule

// File: rtl/fdt_qual_timer.sv
module fdt_qual_timer #(
   parameter int CNT_W  = 12,
   parameter bit BYPASS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             raw,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             qual
);

   generate
      if (BYPASS) begin : g_direct
         logic unused_inputs;
         assign unused_inputs = ^{tick, restart, limit};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) qual <= 1'b0;
            else        qual <= raw;
         end
      end else begin : g_timed
         logic [CNT_W-1:0] cnt;
         logic             expire;

         assign expire = (cnt >= (limit - CNT_W'(1)));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               qual <= 1'b0;
            end else if (!raw) begin
               cnt  <= '0;
               qual <= 1'b0;
            end else if (restart) begin
               cnt  <= '0;
            end else if (tick && !qual) begin
               if (expire) begin
                  cnt  <= '0;
                  qual <= 1'b1;
               end else begin
                  cnt  <= cnt + CNT_W'(1);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fdt_out_map.sv
module fdt_out_map
   import fdt_pkg::*;
#(
   parameter logic [NUM_FAULTS-1:0] ROUTE = CHG_ROUTE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  latch_en,
   input  logic                  pol_high,
   input  logic [NUM_FAULTS-1:0] qual,
   output logic                  active,
   output logic                  level
);

   logic hit;
   logic held;

   assign hit = |(qual & ROUTE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               held <= 1'b0;
      else if (latch_en && hit) held <= 1'b1;
   end

   assign active = hit | held;
   assign level  = pol_high ? active : ~active;

endmodule

// File: rtl/fdt_prot_ctrl.sv
module fdt_prot_ctrl
   import fdt_pkg::*;
#(
   parameter int BASE_TICKS = 250,
   parameter int TEST_TICKS = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             raw_ov,
   input  logic             raw_uv,
   input  logic             raw_ow,
   input  logic             raw_ot,
   input  logic             raw_osc,
   input  logic [2:0]       ov_dly_sel,
   input  logic [2:0]       uv_dly_sel,
   input  logic             latch_en,
   input  logic             pol_high,
   input  logic             test_req,
   output logic             chg_out,
   output logic             dsg_out,
   output logic             fault_mode
);

   localparam int LONGEST = BASE_TICKS << MAX_SHIFT;
   localparam int CNT_W   = $clog2(LONGEST + 1);

   generate
      if (BASE_TICKS < 1) begin : g_bad_base
         $error("BASE_TICKS must be at least 1");
      end
      if (TEST_TICKS < 1 || TEST_TICKS > LONGEST) begin : g_bad_test
         $error("TEST_TICKS must lie between 1 and the longest delay");
      end
   endgenerate

   logic [NUM_FAULTS-1:0] raw_vec;
   logic [NUM_FAULTS-1:0] qual_vec;
   logic [SEL_W-1:0]      code_vec [NUM_FAULTS];
   logic                  test_q;
   logic                  restart;
   logic                  chg_act;
   logic                  dsg_act;

   assign raw_vec[F_OV]  = raw_ov;
   assign raw_vec[F_UV]  = raw_uv;
   assign raw_vec[F_OW]  = raw_ow;
   assign raw_vec[F_OT]  = raw_ot;
   assign raw_vec[F_OSC] = raw_osc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) test_q <= 1'b0;
      else        test_q <= test_req;
   end

   assign restart = test_q ^ test_req;

   generate
      for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_fault
         logic [CNT_W-1:0] limit;

         if (i == int'(F_OV)) begin : g_code
            assign code_vec[i] = ov_dly_sel;
         end else if (i == int'(F_UV)) begin : g_code
            assign code_vec[i] = uv_dly_sel;
         end else begin : g_code
            assign code_vec[i] = SEL_W'(MAX_SHIFT);
         end

         fdt_delay_sel #(
            .BASE_TICKS (BASE_TICKS),
            .TEST_TICKS (TEST_TICKS),
            .CNT_W      (CNT_W)
         ) u_dly (
            .code    (code_vec[i]),
            .test_on (test_q),
            .limit   (limit)
         );

         fdt_qual_timer #(
            .CNT_W  (CNT_W),
            .BYPASS (i == int'(F_OSC))
         ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .raw     (raw_vec[i]),
            .restart (restart),
            .limit   (limit),
            .qual    (qual_vec[i])
         );
      end
   endgenerate

   fdt_out_map #(.ROUTE(CHG_ROUTE)) u_chg (
      .clk      (clk),
      .rst_n    (rst_n),
      .latch_en (latch_en),
      .pol_high (pol_high),
      .qual     (qual_vec),
      .active   (chg_act),
      .level    (chg_out)
   );

   fdt_out_map #(.ROUTE(DSG_ROUTE)) u_dsg (
      .clk      (clk),
      .rst_n    (rst_n),
      .latch_en (latch_en),
      .pol_high (pol_high),
      .qual     (qual_vec),
      .active   (dsg_act),
      .level    (dsg_out)
   );

   assign fault_mode = chg_act | dsg_act;

endmodule

// File: rtl/fdt_prot_chk.sv
module fdt_prot_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       raw_ov,
   input logic       raw_osc,
   input logic       latch_en,
   input logic       pol_high,
   input logic [4:0] qual_vec,
   input logic       chg_out,
   input logic       dsg_out,
   input logic       fault_mode
);

   p_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fault_mode == ((chg_out == pol_high) || (dsg_out == pol_high)));

   p_osc_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_osc && $stable(pol_high)) |=> (chg_out == pol_high && dsg_out == pol_high));

   p_ov_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual_vec[0]) |-> $past(tick));

   p_ov_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_ov |=> !qual_vec[0]);

   p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && chg_out == pol_high && $stable(pol_high)) |=> (chg_out == pol_high || pol_high != $past(pol_high)));

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_mode |-> (chg_out != pol_high && dsg_out != pol_high));

endmodule

bind fdt_prot_ctrl fdt_prot_chk u_fdt_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .raw_ov     (raw_ov),
   .raw_osc    (raw_osc),
   .latch_en   (latch_en),
   .pol_high   (pol_high),
   .qual_vec   (qual_vec),
   .chg_out    (chg_out),
   .dsg_out    (dsg_out),
   .fault_mode (fault_mode)
);

// File: tb/fdt_prot_ctrl_bench.sv
`timescale 1ns/1ps
module fdt_prot_ctrl_bench;

   localparam int BASE = 4;
   localparam int TST  = 3;
   localparam int LONG = BASE << 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       raw_ov = 1'b0, raw_uv = 1'b0, raw_ow = 1'b0, raw_ot = 1'b0, raw_osc = 1'b0;
   logic [2:0] ov_dly_sel = 3'd0, uv_dly_sel = 3'd0;
   logic       latch_en = 1'b0, pol_high = 1'b1, test_req = 1'b0;
   logic       chg_out, dsg_out, fault_mode;

   int n_tests = 0;
   int n_fail  = 0;
   int tper    = 1;
   int tphase  = 0;
   int nticks  = 0;

   always #2 clk = ~clk;

   fdt_prot_ctrl #(.BASE_TICKS(BASE), .TEST_TICKS(TST)) u_fdt_prot_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .raw_ov(raw_ov), .raw_uv(raw_uv), .raw_ow(raw_ow), .raw_ot(raw_ot), .raw_osc(raw_osc),
      .ov_dly_sel(ov_dly_sel), .uv_dly_sel(uv_dly_sel),
      .latch_en(latch_en), .pol_high(pol_high), .test_req(test_req),
      .chg_out(chg_out), .dsg_out(dsg_out), .fault_mode(fault_mode)
   );

   function automatic bit is_act(input logic lvl);
      return lvl == pol_high;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock: drive tick at the negedge, count it at the posedge
   task automatic cyc();
      tick = ((tphase % tper) == 0);
      tphase++;
      @(posedge clk);
      if (tick) nticks++;
      @(negedge clk);
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) cyc();
   endtask

   task automatic clear_raw();
      raw_ov = 0; raw_uv = 0; raw_ow = 0; raw_ot = 0; raw_osc = 0;
      run(2);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clear_raw();
      test_req = 1'b0;
      latch_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // ticks seen until the chosen line is active; other_seen marks the other line
   task automatic measure(input bit use_dsg, output int ticks, output bit other_seen);
      nticks = 0;
      other_seen = 0;
      ticks = -1;
      for (int k = 0; k < 600; k++) begin
         cyc();
         if (is_act(use_dsg ? chg_out : dsg_out)) other_seen = 1;
         if (is_act(use_dsg ? dsg_out : chg_out)) begin
            ticks = nticks;
            break;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int  t;
      int  exp_n;
      bit  oth;

      @(negedge clk);
      for (int p = 1; p >= 0; p--) begin
         pol_high = p[0];
         do_reset();
         // R1 reset state, R11 inactive level
         chk(chg_out == !pol_high && dsg_out == !pol_high, "R1 R11 idle levels", {chg_out, dsg_out}, {!pol_high, !pol_high});
         chk(fault_mode == 1'b0, "R1 R12 mode after reset", fault_mode, 0);

         for (int s = 0; s < 8; s++) begin
            exp_n = BASE << ((s > 4) ? 4 : s);
            // R2 over-voltage on the charge line only
            ov_dly_sel = 3'(s);
            raw_ov = 1;
            measure(0, t, oth);
            chk(t == exp_n, "R2 ov delay ticks", t, exp_n);
            chk(!oth, "R2 discharge line stays quiet", oth, 0);
            chk(fault_mode, "R12 mode with ov", fault_mode, 1);
            chk(chg_out == pol_high, "R11 active level", chg_out, pol_high);
            clear_raw();
            chk(!fault_mode, "R7 ov released", fault_mode, 0);
            // R3 under-voltage on the discharge line only
            uv_dly_sel = 3'(s);
            raw_uv = 1;
            measure(1, t, oth);
            chk(t == exp_n, "R3 uv delay ticks", t, exp_n);
            chk(!oth, "R3 charge line stays quiet", oth, 0);
            clear_raw();
         end

         // R4 broken wire and over-temperature drive both lines
         raw_ow = 1;
         measure(0, t, oth);
         chk(t == LONG, "R4 wire delay ticks", t, LONG);
         chk(is_act(dsg_out), "R4 wire on discharge", dsg_out, pol_high);
         clear_raw();
         raw_ot = 1;
         measure(1, t, oth);
         chk(t == LONG, "R4 temp delay ticks", t, LONG);
         chk(is_act(chg_out), "R4 temp on charge", chg_out, pol_high);
         clear_raw();
      end

      pol_high = 1;
      do_reset();

      // R2 sparse tick: only tick cycles count
      tper = 3; tphase = 0;
      ov_dly_sel = 3'd2;
      raw_ov = 1;
      measure(0, t, oth);
      chk(t == (BASE << 2), "R2 sparse tick count", t, BASE << 2);
      clear_raw();
      tper = 1;

      // R5 oscillator fault is immediate in both directions
      raw_osc = 1;
      cyc();
      chk(chg_out && dsg_out, "R5 osc asserts next cycle", {chg_out, dsg_out}, 3);
      raw_osc = 0;
      cyc();
      chk(!chg_out && !dsg_out, "R5 osc releases next cycle", {chg_out, dsg_out}, 0);

      // R6 a one-cycle dropout restarts the timer
      ov_dly_sel = 3'd3;
      raw_ov = 1;
      run((BASE << 3) - 1);
      raw_ov = 0;
      cyc();
      chk(!chg_out, "R6 not active before expiry", chg_out, 0);
      raw_ov = 1;
      measure(0, t, oth);
      chk(t == (BASE << 3), "R6 full delay after dropout", t, BASE << 3);
      clear_raw();

      // R7 shared fault release per line
      uv_dly_sel = 3'd0;
      raw_uv = 1; raw_ot = 1;
      measure(1, t, oth);
      chk(t == BASE && !oth, "R7 uv first on discharge", t, BASE);
      measure(0, t, oth);
      chk(t == LONG - BASE, "R7 temp later on charge", t, LONG - BASE);
      raw_ot = 0;
      cyc();
      chk(!chg_out && dsg_out, "R7 charge drops, discharge held by uv", {chg_out, dsg_out}, 1);
      raw_uv = 0;
      cyc();
      chk(!dsg_out && !fault_mode, "R7 discharge drops", {dsg_out, fault_mode}, 0);

      // R10 test request mid-count restarts the timer
      ov_dly_sel = 3'd4;
      raw_ov = 1;
      run(10);
      test_req = 1;
      measure(0, t, oth);
      chk(t == TST + 1, "R10 restart on test entry", t, TST + 1);
      clear_raw();

      // R9 test delays for every timed fault
      uv_dly_sel = 3'd4;
      raw_uv = 1;
      measure(1, t, oth);
      chk(t == TST, "R9 test uv delay", t, TST);
      clear_raw();
      raw_ow = 1;
      measure(0, t, oth);
      chk(t == TST, "R9 test wire delay", t, TST);
      clear_raw();
      test_req = 0;
      run(2);
      raw_ow = 1;
      measure(0, t, oth);
      chk(t == LONG, "R9 normal delay after exit", t, LONG);
      clear_raw();

      // R8 latch holds until reset
      latch_en = 1;
      ov_dly_sel = 3'd0;
      raw_ov = 1;
      measure(0, t, oth);
      chk(t == BASE, "R8 latched ov delay", t, BASE);
      raw_ov = 0;
      run(6);
      chk(chg_out && !dsg_out, "R8 charge held after drop", {chg_out, dsg_out}, 2);
      chk(fault_mode, "R8 R12 mode held", fault_mode, 1);
      pol_high = 0;
      do_reset();
      chk(chg_out && dsg_out && !fault_mode, "R8 R1 reset clears latch", {chg_out, dsg_out, fault_mode}, 6);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule